// File: doc/BRIEF.md
# Time-Slotted Channel Calibration Sequencer

This block drives a sinusoidal test tone into a bank of transmit channels one channel at a time, so that the amplitude and phase each channel adds can be measured afterwards and compared. The tone comes from a phase-accumulator synthesizer running at a programmed frequency word. A sweep visits every channel in ascending index order. Each channel gets one slot of equal length, and all other channel outputs are held at zero during that slot.

The slot length must advance the tone phase by a whole number of turns. The accumulator starts at phase zero when a sweep begins and then runs freely across slot boundaries. Every slot therefore opens at the same tone phase, and downstream measurement needs no per-slot phase correction. A start command whose settings break this condition is refused with a one-cycle reject pulse. Inside each slot, a capture strobe rises after a programmable settling delay and stays high until the slot ends. The strobe comes with the index of the channel being excited, so a capture engine can record the looped-back samples. A one-cycle done pulse marks the end of the sweep.

Top module: `cal_sweep_seq`

## Requirements
- R1: During and after reset, until a start is accepted, every channel output is zero and busy, cap_valid, done and start_rej are low.
- R2: A start pulse seen while idle is accepted only when slot_len is nonzero, settle_len is less than slot_len, and (slot_len × freq_word) mod 2^ACC_W is zero. Otherwise start_rej is high for exactly the one cycle after the start, busy stays low and the outputs stay zero.
- R3: After an accepted start, channels 0, 1, …, NCH-1 are excited in that order, each for exactly slot_len cycles. cap_chan shows the excited channel, and every other channel output is zero.
- R4: The phase is zero in the first cycle of the sweep and grows by freq_word every cycle, with no reset at slot boundaries. The excited channel's sample for phase p is computed as follows. Let quad = p[ACC_W-1:ACC_W-2] and idx = the next LUT_AW bits below quad. Let a = idx when quad[0]=0, and a = 2^LUT_AW − idx otherwise. Then m = floor(AMP·a·(2Q−a)/Q²), with Q = 2^LUT_AW and AMP = 2^(SMP_W-1)−1. The sample is m when quad[1]=0 and −m (two's complement) when quad[1]=1.
- R5: cap_valid is high in exactly those sweep cycles whose offset within the slot (0 for the slot's first cycle) is at least settle_len.
- R6: One cycle after the last cycle of the last slot, done is high for exactly one cycle, busy is low, and all channel outputs and cap_valid are zero.
- R7: A start pulse during a sweep is ignored. The running sweep keeps its frequency, slot length, settling delay and channel order, and no reject pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sweep start request, sampled while idle |
| freq_word | input | ACC_W | Tone phase increment per cycle |
| slot_len | input | SLOT_W | Slot length in cycles |
| settle_len | input | SLOT_W | Cycles from slot start before capture begins |
| ch_tx | output | NCH*SMP_W | Per-channel signed tone samples, channel i at bits [i*SMP_W +: SMP_W] |
| cap_valid | output | 1 | Capture window strobe |
| cap_chan | output | $clog2(NCH) | Index of the channel being excited |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| start_rej | output | 1 | One-cycle pulse for a refused start |

## Verification
The bench builds the block with NCH=4, SLOT_W=8, ACC_W=32, LUT_AW=6 and SMP_W=16. With four channels, a full sweep with every slot boundary, the wrap of the channel index and the done pulse fits into a few dozen cycles. The 8-bit slot field makes the largest legal settling delay (slot_len−1) and slots of one and several tone periods easy to reach. The 32-bit accumulator keeps the whole-turn rule on its true modulus, so frequency words that barely fail the rule can be tried next to ones that pass, and the full quadrant folding of the sine can be compared sample by sample.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cal_sine_lut.sv
// Quarter-wave folded sine shape, computed arithmetically from the address.
module cal_sine_lut #(
    parameter int LUT_AW = 6,
    parameter int SMP_W  = 16
) (
    input  logic [LUT_AW+1:0] ph_top,
    output logic [SMP_W-1:0]  sample
);
    localparam int          Q   = 1 << LUT_AW;
    localparam int unsigned AMP = (1 << (SMP_W - 1)) - 1;
    localparam int          MW  = SMP_W + 2 * LUT_AW + 4;
    localparam int          SH  = 2 * LUT_AW;

    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [LUT_AW:0]   a;
    logic [LUT_AW+1:0] b;
    logic [MW-1:0]     prod;
    logic [SMP_W-1:0]  mag;

    always_comb begin
        quad = ph_top[LUT_AW+1 -: 2];
        idx  = ph_top[LUT_AW-1:0];
        a    = quad[0] ? ((LUT_AW+1)'(Q) - {1'b0, idx}) : {1'b0, idx};
        b    = (LUT_AW+2)'(2 * Q) - {1'b0, a};
        prod = MW'(AMP) * MW'(a) * MW'(b);
        mag  = SMP_W'(prod >> SH);
        sample = quad[1] ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/cal_phase_acc.sv
// Free-running phase accumulator; cleared only at sweep start.
module cal_phase_acc #(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [ACC_W-1:0] inc,
    output logic [OUT_W-1:0] ph_top
);
    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_t;

    acc_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.phase = '0;
        end else if (step) begin
            r_d.phase = r_q.phase + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ph_top = r_q.phase[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/cal_slot_ctrl.sv
// Sweep state machine: start validation, slot and channel counting, capture window.
module cal_slot_ctrl
    import cal_seq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int SLOT_W = 16,
    parameter int ACC_W  = 32,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ACC_W-1:0]  freq_word,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic [SLOT_W-1:0] settle_len,
    output logic              busy,
    output logic              done,
    output logic              start_rej,
    output logic [CH_W-1:0]   ch_idx,
    output logic              cap_valid,
    output logic              acc_clear,
    output logic [ACC_W-1:0]  acc_inc
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CH_W-1:0]   ch;
        logic [SLOT_W-1:0] cnt;
        logic [ACC_W-1:0]  fw;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] settle;
        logic              done;
        logic              rej;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [ACC_W-1:0] turn_prod;
    logic             cfg_ok;
    logic             clr_d;

    always_comb begin
        turn_prod = freq_word * ACC_W'(slot_len);
        cfg_ok    = (slot_len != '0) && (settle_len < slot_len) && (turn_prod == '0);

        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.rej  = 1'b0;
        clr_d    = 1'b0;

        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    if (cfg_ok) begin
                        r_d.st     = SEQ_RUN;
                        r_d.ch     = '0;
                        r_d.cnt    = '0;
                        r_d.fw     = freq_word;
                        r_d.slot   = slot_len;
                        r_d.settle = settle_len;
                        clr_d      = 1'b1;
                    end else begin
                        r_d.rej = 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (r_q.cnt == r_q.slot - 1'b1) begin
                    r_d.cnt = '0;
                    if (r_q.ch == LAST_CH) begin
                        r_d.st   = SEQ_IDLE;
                        r_d.ch   = '0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.ch = r_q.ch + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st == SEQ_RUN);
    assign done      = r_q.done;
    assign start_rej = r_q.rej;
    assign ch_idx    = r_q.ch;
    assign cap_valid = busy && (r_q.cnt >= r_q.settle);
    assign acc_clear = clr_d;
    assign acc_inc   = r_q.fw;
endmodule

// File: rtl/cal_sweep_seq.sv
// Top: tone synthesis plus per-channel routing for a time-slotted sweep.
module cal_sweep_seq #(
    parameter int NCH    = 16,
    parameter int SLOT_W = 16,
    parameter int ACC_W  = 32,
    parameter int LUT_AW = 6,
    parameter int SMP_W  = 16,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ACC_W-1:0]     freq_word,
    input  logic [SLOT_W-1:0]    slot_len,
    input  logic [SLOT_W-1:0]    settle_len,
    output logic [NCH*SMP_W-1:0] ch_tx,
    output logic                 cap_valid,
    output logic [CH_W-1:0]      cap_chan,
    output logic                 busy,
    output logic                 done,
    output logic                 start_rej
);
    localparam int PT_W = LUT_AW + 2;

    logic              acc_clear;
    logic [ACC_W-1:0]  acc_inc;
    logic [PT_W-1:0]   ph_top;
    logic [SMP_W-1:0]  tone;

    cal_slot_ctrl #(
        .NCH   (NCH),
        .SLOT_W(SLOT_W),
        .ACC_W (ACC_W),
        .CH_W  (CH_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .freq_word (freq_word),
        .slot_len  (slot_len),
        .settle_len(settle_len),
        .busy      (busy),
        .done      (done),
        .start_rej (start_rej),
        .ch_idx    (cap_chan),
        .cap_valid (cap_valid),
        .acc_clear (acc_clear),
        .acc_inc   (acc_inc)
    );

    cal_phase_acc #(
        .ACC_W(ACC_W),
        .OUT_W(PT_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc_clear),
        .step  (busy),
        .inc   (acc_inc),
        .ph_top(ph_top)
    );

    cal_sine_lut #(
        .LUT_AW(LUT_AW),
        .SMP_W (SMP_W)
    ) u_lut (
        .ph_top(ph_top),
        .sample(tone)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_route
        assign ch_tx[i*SMP_W +: SMP_W] =
            (busy && (cap_chan == CH_W'(i))) ? tone : '0;
    end
endmodule

// File: rtl/cal_sweep_seq_chk.sv
module cal_sweep_seq_chk #(
    parameter int NCH   = 16,
    parameter int SMP_W = 16,
    parameter int CH_W  = $clog2(NCH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH*SMP_W-1:0] ch_tx,
    input logic                 cap_valid,
    input logic [CH_W-1:0]      cap_chan,
    input logic                 busy,
    input logic                 done,
    input logic                 start_rej
);
    logic [NCH-1:0] live;
    for (genvar i = 0; i < NCH; i++) begin : g_live
        assign live[i] = |ch_tx[i*SMP_W +: SMP_W];
    end

    p_single_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(live));

    p_chan_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cap_chan != $past(cap_chan)))
        |-> (cap_chan == $past(cap_chan) + CH_W'(1)));

    p_cap_in_sweep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> busy);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((ch_tx == '0) && !cap_valid));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && ($past(cap_chan) == CH_W'(NCH - 1)) && !busy));

    p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_rej |-> (!busy && !$past(busy)));
endmodule

bind cal_sweep_seq cal_sweep_seq_chk #(
    .NCH  (NCH),
    .SMP_W(SMP_W),
    .CH_W (CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_tx    (ch_tx),
    .cap_valid(cap_valid),
    .cap_chan (cap_chan),
    .busy     (busy),
    .done     (done),
    .start_rej(start_rej)
);

// File: tb/cal_sweep_seq_bench.sv
`timescale 1ns/1ps
module cal_sweep_seq_bench;
    localparam int NCH = 4, SLOT_W = 8, ACC_W = 32, LUT_AW = 6, SMP_W = 16;
    localparam int CH_W = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [ACC_W-1:0]     freq_word = '0;
    logic [SLOT_W-1:0]    slot_len = '0;
    logic [SLOT_W-1:0]    settle_len = '0;
    logic [NCH*SMP_W-1:0] ch_tx;
    logic                 cap_valid;
    logic [CH_W-1:0]      cap_chan;
    logic                 busy, done, start_rej;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cal_sweep_seq #(.NCH(NCH), .SLOT_W(SLOT_W), .ACC_W(ACC_W),
                    .LUT_AW(LUT_AW), .SMP_W(SMP_W)) u_cal_sweep_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_word(freq_word),
        .slot_len(slot_len), .settle_len(settle_len), .ch_tx(ch_tx),
        .cap_valid(cap_valid), .cap_chan(cap_chan), .busy(busy),
        .done(done), .start_rej(start_rej));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Sine shape as stated in R4.
    function automatic logic [15:0] ref_sine(input logic [31:0] ph);
        longint q, a, m;
        logic [1:0] quad;
        quad = ph[31:30];
        q = 64;
        a = quad[0] ? (q - longint'(ph[29:24])) : longint'(ph[29:24]);
        m = (32767 * a * (2 * q - a)) / (q * q);
        return quad[1] ? 16'(-m) : 16'(m);
    endfunction

    task automatic check_idle(input string req);
        chk(ch_tx == '0, req, "ch_tx idle", ch_tx, 64'd0);
        chk({busy, cap_valid} == 2'b00, req, "busy/cap idle",
            {62'd0, busy, cap_valid}, 64'd0);
    endtask

    // One full sweep, checked every cycle; optional stray start mid-sweep (R7).
    task automatic run_sweep(input logic [31:0] fw, input int slot, input int settle,
                             input bit poke);
        logic [31:0] ph;
        logic [63:0] exp_tx;
        @(negedge clk);
        freq_word = fw; slot_len = SLOT_W'(slot); settle_len = SLOT_W'(settle);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ph = '0;
        for (int t = 0; t < NCH * slot; t++) begin
            int c, off;
            c = t / slot;
            off = t % slot;
            exp_tx = '0;
            exp_tx[c*SMP_W +: SMP_W] = ref_sine(ph);
            chk(ch_tx == exp_tx, "R3/R4", "ch_tx", ch_tx, exp_tx);
            chk(cap_valid == (off >= settle), "R5", "cap_valid",
                64'(cap_valid), 64'(off >= settle));
            chk(cap_chan == CH_W'(c) && busy, "R3", "cap_chan/busy",
                {busy, 61'd0, cap_chan}, {1'b1, 61'd0, 2'(c)});
            chk(!done && !start_rej, "R7", "done/rej in sweep",
                {62'd0, done, start_rej}, 64'd0);
            ph = ph + fw;
            if (poke && t == slot + 1) begin
                start = 1'b1; freq_word = 32'h1234_5679;
                slot_len = 8'd3; settle_len = 8'd0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1, "R6", "done pulse", 64'(done), 64'd1);
        check_idle("R6");
        @(negedge clk);
        chk(done == 1'b0, "R6", "done cleared", 64'(done), 64'd0);
        check_idle("R6");
    endtask

    task automatic t_reset;
        check_idle("R1");
        chk({done, start_rej} == 2'b00, "R1", "done/rej reset",
            {62'd0, done, start_rej}, 64'd0);
    endtask

    task automatic t_reject(input logic [31:0] fw, input int slot, input int settle);
        @(negedge clk);
        freq_word = fw; slot_len = SLOT_W'(slot); settle_len = SLOT_W'(settle);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(start_rej == 1'b1, "R2", "reject pulse", 64'(start_rej), 64'd1);
        check_idle("R2");
        @(negedge clk);
        chk(start_rej == 1'b0, "R2", "reject one cycle", 64'(start_rej), 64'd0);
        check_idle("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();                               // R1
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();                               // R1 after release
        run_sweep(32'h1000_0000, 16, 4, 1'b0);   // R3 R4 R5: one turn per slot
        run_sweep(32'h3000_0000, 16, 0, 1'b0);   // R4: three turns per slot
        run_sweep(32'hA000_0000, 8, 7, 1'b0);    // R5: largest settle
        run_sweep(32'hF000_0000, 16, 15, 1'b1);  // R7: stray start mid-sweep
        t_reject(32'h1000_0000, 10, 2);          // R2: not whole turns
        t_reject(32'h1000_0000, 0, 0);           // R2: zero slot
        t_reject(32'h1000_0000, 16, 16);         // R2: settle not below slot
        t_reject(32'h1000_0001, 16, 0);          // R2: off by one LSB
        run_sweep(32'h2000_0000, 8, 1, 1'b0);    // R2: accepted after rejects
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule